// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Self-Refresh Sequencing

This block sits between a simple request port and a dynamic memory array of 2048 rows by 2048 columns by 4 bits. A requester presents a 22-bit address with a valid/ready handshake. The upper eleven bits select the row and the lower eleven bits select the column. The controller drives the row and then the column over one shared 11-bit address bus. It raises a row strobe for the row phase and adds a column strobe for the column phase. Both strobes then drop for a precharge gap. Reads return one 4-bit word on a single-cycle response pulse. Writes return no response.

The array loses its charge unless every row is restored regularly. To handle this, the controller has a free-running interval timer that raises a refresh-due flag every `REFRESH_PERIOD` cycles, whether or not any traffic arrives. When the flag is up, the controller first lets any access already in flight finish. It then performs a row-only strobe cycle on the row held in an internal refresh counter. The array reads that row and writes it back. The counter then advances and wraps from the last row to row 0. While refresh is due or running, `req_ready` stays low, so the requester sees the memory as busy.

The sequencer has six states. `ST_IDLE` goes to `ST_REF_ROW` when refresh is due, or to `ST_ACC_ROW` on an accepted request. `ST_ACC_ROW` goes to `ST_ACC_COL`, then to `ST_ACC_PRE`, then back to `ST_IDLE`. `ST_REF_ROW` goes to `ST_REF_PRE`, then back to `ST_IDLE`. Each non-idle state lasts a fixed, parameterised number of cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, `row_strobe`, `col_strobe`, `mem_we` and `rsp_valid` are low and `req_ready` is high; the first refresh cycle targets row 0.
- R2: During an access, `mem_addr` carries `req_addr[21:11]` while only `row_strobe` is high, and `req_addr[10:0]` while `col_strobe` is high.
- R3: An accepted access drives `row_strobe` alone for `T_ROW` cycles, then both strobes for `T_COL` cycles, then neither for `T_PRE` cycles, then returns to idle.
- R4: For a write, `mem_we` is high and `mem_wdata` equals the write data in every column-phase cycle; `mem_we` is low in all other cycles.
- R5: A read raises `rsp_valid` for exactly one cycle, the first cycle after the column phase, with `rsp_rdata` equal to the array word at the requested address; a write raises no response.
- R6: The refresh-due flag is raised every `REFRESH_PERIOD` cycles counted from reset, independent of traffic.
- R7: A refresh cycle drives `row_strobe` with the refresh row for `T_ROW` cycles, keeping `col_strobe` and `mem_we` low, followed by `T_PRE` cycles with both strobes low.
- R8: `req_ready` is high only when the controller is idle and no refresh is due; a request is taken only at a clock edge where both `req_valid` and `req_ready` are high.
- R9: An access in progress is completed before a due refresh starts, and a due refresh starts ahead of any request that is pending at that time.
- R10: The refresh row advances by one after each refresh cycle and wraps from row 2047 to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 11 | Shared row/column address bus |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 4 | Data to the array |
| mem_rdata | input | 4 | Data from the array |

## Verification
The assertions assume the array answers only through `mem_rdata` and that the request inputs change only away from the rising edge. They also assume `req_valid` is not held against a busy controller in any way that changes the request fields before acceptance. The stimulus meets these assumptions by driving every input on the falling edge. Once the stimulus raises `req_valid`, it keeps the address, direction and data unchanged until the cycle after the edge where `req_ready` was seen high. A behavioural array in the bench captures the row on the row phase and answers or stores on the column phase. This mirrors how a real part uses the strobes, so the pin sequences the assertions constrain are exactly the ones the array consumes.

// File: rtl/dramctl_pkg.sv
`timescale 1ns/1ps
package dramctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC_ROW,
        ST_ACC_COL,
        ST_ACC_PRE,
        ST_REF_ROW,
        ST_REF_PRE
    } ctl_state_e;

    typedef enum logic [1:0] {
        PIN_NONE,
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } pin_sel_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dramctl_refresh_timer.sv
`timescale 1ns/1ps
module dramctl_refresh_timer #(
    parameter int REFRESH_PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = (REFRESH_PERIOD > 1) ? $clog2(REFRESH_PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(REFRESH_PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RELOAD;
            due <= 1'b0;
        end else begin
            cnt <= expire ? RELOAD : cnt - 1'b1;
            due <= expire | (due & ~ack);
        end
    end
endmodule

// File: rtl/dramctl_row_counter.sv
`timescale 1ns/1ps
module dramctl_row_counter #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/dramctl_addr_mux.sv
`timescale 1ns/1ps
module dramctl_addr_mux
    import dramctl_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 11
) (
    input  pin_sel_e         sel,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] pins
);
    always_comb begin
        unique case (sel)
            PIN_ROW:  pins = acc_row;
            PIN_COL:  pins = ROW_W'(acc_col);
            PIN_REF:  pins = ref_row;
            default:  pins = '0;
        endcase
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
`timescale 1ns/1ps
module dram_mux_ctrl
    import dramctl_pkg::*;
#(
    parameter int ROW_W          = 11,
    parameter int COL_W          = 11,
    parameter int DATA_W         = 4,
    parameter int T_ROW          = 2,
    parameter int T_COL          = 2,
    parameter int T_PRE          = 1,
    parameter int REFRESH_PERIOD = 64,
    localparam int ADDR_W        = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              row_strobe,
    output logic              col_strobe,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int PH_MAX = max3(T_ROW, T_COL, T_PRE);
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [PH_W-1:0] ROW_LAST = PH_W'(T_ROW - 1);
    localparam logic [PH_W-1:0] COL_LAST = PH_W'(T_COL - 1);
    localparam logic [PH_W-1:0] PRE_LAST = PH_W'(T_PRE - 1);

    ctl_state_e        state, nxt;
    logic [PH_W-1:0]   ph;
    logic              ph_last;
    logic              ref_due, ref_ack, ref_step;
    logic [ROW_W-1:0]  ref_row;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wd;
    logic              take;
    pin_sel_e          pin_sel;

    dramctl_refresh_timer #(.REFRESH_PERIOD(REFRESH_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    dramctl_row_counter #(.ROW_W(ROW_W)) u_rowcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_step),
        .row   (ref_row)
    );

    dramctl_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
        .sel     (pin_sel),
        .acc_row (lat_row),
        .acc_col (lat_col),
        .ref_row (ref_row),
        .pins    (mem_addr)
    );

    // phase end for the current state
    always_comb begin
        unique case (state)
            ST_ACC_ROW, ST_REF_ROW: ph_last = (ph == ROW_LAST);
            ST_ACC_COL:             ph_last = (ph == COL_LAST);
            ST_ACC_PRE, ST_REF_PRE: ph_last = (ph == PRE_LAST);
            default:                ph_last = 1'b0;
        endcase
    end

    assign ref_ack  = (state == ST_IDLE) && ref_due;
    assign take     = (state == ST_IDLE) && !ref_due && req_valid;
    assign ref_step = (state == ST_REF_PRE) && ph_last;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_due)        nxt = ST_REF_ROW;
                else if (req_valid) nxt = ST_ACC_ROW;
            end
            ST_ACC_ROW: if (ph_last) nxt = ST_ACC_COL;
            ST_ACC_COL: if (ph_last) nxt = ST_ACC_PRE;
            ST_ACC_PRE: if (ph_last) nxt = ST_IDLE;
            ST_REF_ROW: if (ph_last) nxt = ST_REF_PRE;
            ST_REF_PRE: if (ph_last) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == ST_IDLE) ph <= '0;
            else                                  ph <= ph + 1'b1;
        end
    end

    // request capture and read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_row   <= '0;
            lat_col   <= '0;
            lat_we    <= 1'b0;
            lat_wd    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (take) begin
                lat_row <= req_addr[ADDR_W-1:COL_W];
                lat_col <= req_addr[COL_W-1:0];
                lat_we  <= req_we;
                lat_wd  <= req_wdata;
            end
            rsp_valid <= (state == ST_ACC_COL) && ph_last && !lat_we;
            if ((state == ST_ACC_COL) && ph_last && !lat_we)
                rsp_rdata <= mem_rdata;
        end
    end

    // pin outputs
    always_comb begin
        req_ready  = 1'b0;
        row_strobe = 1'b0;
        col_strobe = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        pin_sel    = PIN_NONE;
        unique case (state)
            ST_IDLE:    req_ready = !ref_due;
            ST_ACC_ROW: begin
                row_strobe = 1'b1;
                pin_sel    = PIN_ROW;
            end
            ST_ACC_COL: begin
                row_strobe = 1'b1;
                col_strobe = 1'b1;
                pin_sel    = PIN_COL;
                mem_we     = lat_we;
                mem_wdata  = lat_we ? lat_wd : '0;
            end
            ST_REF_ROW: begin
                row_strobe = 1'b1;
                pin_sel    = PIN_REF;
            end
            ST_ACC_PRE, ST_REF_PRE: pin_sel = PIN_NONE;
            default:    pin_sel = PIN_NONE;
        endcase
    end
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
`timescale 1ns/1ps
module dram_mux_ctrl_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [ROW_W-1:0] mem_addr,
    input logic             row_strobe,
    input logic             col_strobe,
    input logic             mem_we
);
    // R3
    col_under_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_strobe);

    // R3
    row_before_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_strobe) |-> $past(row_strobe));

    // R8
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!row_strobe && !col_strobe));

    // R4
    write_in_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> col_strobe);

    // R5
    rsp_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!row_strobe && !col_strobe));

    // R5
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    col_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_strobe && $past(col_strobe)) |-> $stable(mem_addr));

    // R2
    row_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_strobe && !col_strobe && $past(row_strobe) && !$past(col_strobe)) |-> $stable(mem_addr));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .mem_we     (mem_we)
);

// File: tb/dram_mux_ctrl_bench.sv
`timescale 1ns/1ps
module dram_mux_ctrl_bench;
    localparam int ROW_W   = 11;
    localparam int COL_W   = 11;
    localparam int DATA_W  = 4;
    localparam int T_ROW   = 2;
    localparam int T_COL   = 2;
    localparam int T_PRE   = 1;
    localparam int PERIOD  = 24;
    localparam int ROWS    = 1 << ROW_W;
    localparam int ACC_LEN = T_ROW + T_COL + T_PRE;
    localparam int REF_LEN = T_ROW + T_PRE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [21:0]       req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ROW_W-1:0]  mem_addr;
    logic              row_strobe, col_strobe, mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dram_mux_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE),
        .REFRESH_PERIOD(PERIOD)
    ) u_dram_mux_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .row_strobe(row_strobe), .col_strobe(col_strobe),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [3:0] fill(input int a);
        return 4'(a ^ (a >> 4) ^ (a >> 9) ^ 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural array: row captured in row phase, column phase reads or writes
    logic [3:0] arr [int];
    int         arr_row = 0;
    always @(negedge clk) begin
        if (row_strobe && !col_strobe) arr_row = int'(mem_addr);
        if (col_strobe) begin
            int a;
            a = (arr_row << COL_W) | int'(mem_addr);
            if (mem_we) arr[a] = mem_wdata;
            else mem_rdata <= arr.exists(a) ? arr[a] : fill(a);
        end
    end

    // reference model: timeline of the pins, advanced on each rising edge
    logic [3:0] refmem [int];
    int  tmr, kind, idx, ref_row, wraps, r9_seen;
    bit  due, lat_we, running;
    int  lat_row, lat_col, lat_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            tmr = PERIOD - 1; due = 0; kind = 0; idx = 0; ref_row = 0;
            wraps = 0; r9_seen = 0; running = 0;
        end else begin
            bit expired, took;
            running = 1;
            expired = (tmr == 0);
            tmr = expired ? PERIOD - 1 : tmr - 1;
            took = 0;
            if (kind == 0) begin
                if (due) begin
                    kind = 2; idx = 0; took = 1;
                    if (req_valid) r9_seen++;
                end else if (req_valid) begin
                    kind = 1; idx = 0;
                    lat_row = int'(req_addr[21:11]);
                    lat_col = int'(req_addr[10:0]);
                    lat_we = req_we; lat_wd = int'(req_wdata);
                    if (req_we) refmem[int'(req_addr)] = req_wdata;
                end
            end else begin
                idx++;
                if (kind == 1 && idx == ACC_LEN) kind = 0;
                else if (kind == 2 && idx == REF_LEN) begin
                    kind = 0;
                    ref_row = (ref_row + 1) % ROWS;
                    if (ref_row == 0) wraps++;
                end
            end
            due = expired || (due && !took);
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (rst_n && running && !done) begin
            bit e_rs, e_cs, e_rdy, e_we, e_rsp;
            int e_addr, a;
            string tag;
            e_rs  = (kind == 1) ? (idx < T_ROW + T_COL) : (kind == 2) ? (idx < T_ROW) : 1'b0;
            e_cs  = (kind == 1) && idx >= T_ROW && idx < T_ROW + T_COL;
            e_rdy = (kind == 0) && !due;
            e_we  = e_cs && lat_we;
            e_rsp = (kind == 1) && idx == T_ROW + T_COL && !lat_we;
            tag   = (kind == 2) ? "R6/R7" : "R3";
            chk(req_ready == e_rdy, "R8 ready", req_ready, e_rdy);
            chk(row_strobe == e_rs, tag, row_strobe, e_rs);
            chk(col_strobe == e_cs, tag, col_strobe, e_cs);
            chk(mem_we == e_we, "R4 we", mem_we, e_we);
            if (e_rs) begin
                e_addr = e_cs ? lat_col : (kind == 1) ? lat_row : ref_row;
                chk(int'(mem_addr) == e_addr, (kind == 2) ? "R10 refresh row" : "R2 addr",
                    mem_addr, e_addr);
            end
            if (e_we) chk(int'(mem_wdata) == lat_wd, "R4 wdata", mem_wdata, lat_wd);
            chk(rsp_valid == e_rsp, "R5 rsp_valid", rsp_valid, e_rsp);
            if (e_rsp) begin
                a = (lat_row << COL_W) | lat_col;
                chk(rsp_rdata == (refmem.exists(a) ? refmem[a] : fill(a)), "R5 rdata",
                    rsp_rdata, refmem.exists(a) ? refmem[a] : fill(a));
            end
        end
    end

    task automatic do_req(input bit we, input logic [21:0] addr, input logic [3:0] wd);
        bit r;
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        forever begin
            r = req_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [21:0] pat [8];

    initial begin
        pat[0] = 22'h000000; pat[1] = 22'h3FFFFF; pat[2] = 22'h2AAAAA; pat[3] = 22'h155555;
        pat[4] = 22'h3FF800; pat[5] = 22'h0007FF; pat[6] = 22'h000800; pat[7] = 22'h200001;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held and once after release
        chk(req_ready == 1'b1 && !row_strobe && !col_strobe && !mem_we && !rsp_valid,
            "R1 reset outputs", {req_ready, row_strobe, col_strobe, mem_we, rsp_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !row_strobe, "R1 after release", {req_ready, row_strobe}, 2'b10);
        // R2 R4 corner addresses written, then R5 read back
        for (int i = 0; i < 8; i++) do_req(1'b1, pat[i], 4'(i + 9));
        for (int i = 0; i < 8; i++) do_req(1'b0, pat[i], 4'h0);
        // R5 reads of unwritten locations, mixed traffic with random gaps
        for (int i = 0; i < 300; i++) begin
            logic [21:0] a;
            a = 22'($urandom);
            if (i % 3 == 0) a = pat[i % 8] ^ 22'(i & 3);
            do_req(1'($urandom), a, 4'($urandom));
            if ($urandom % 4 == 0) gap(int'($urandom % 30));
        end
        // R9 back-to-back requests collide with due refreshes
        for (int i = 0; i < 200; i++) do_req(1'(i & 1), pat[i % 8], 4'(i));
        chk(r9_seen > 0, "R9 refresh ahead of pending request", r9_seen, 1);
        // R6 R10 no traffic: refresh walks every row and wraps
        gap(ROWS * PERIOD + 200);
        chk(wraps >= 1, "R10 row wrap", wraps, 1);
        for (int i = 0; i < 8; i++) do_req(1'b0, pat[i], 4'h0);
        gap(40);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule